// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block sits in front of a multi-bank on-chip scratchpad. A request is a group of sixteen lane accesses. Each lane carries a word address, an active bit, a store bit and store data. The block spreads words across sixteen banks, finds lanes that collide in a bank, and issues the group over as few clock cycles as those collisions allow. It then returns per-lane read data together with a one-cycle completion pulse.

A bank serves one word per cycle. Lanes that read the same word are merged into one access, and the word is broadcast to all of them. Lanes that touch different words of one bank are spread over successive cycles. Within a bank, the word of the lowest pending lane goes first. A ready/valid handshake holds off the next group until the current one has been answered. Each bank is a simple synchronous RAM whose read returns the contents from before any store in the same cycle.

Top module: `sp_conflict_serializer`

## Requirements
- R1: The bank of a word address is its low four bits (address modulo 16). The row inside the bank is the address divided by 16. A word stored at an address reads back from that same address.
- R2: A group whose active lanes all fall in different banks uses one issue cycle. rsp_valid rises two clock edges after the accepting edge.
- R3: When every active lane reads the same address, that word is returned to all of them and the group uses one issue cycle.
- R4: The number of issue cycles K is the largest count of distinct words addressed in any one bank, with a minimum of 1. rsp_valid is high for exactly one cycle, and it rises K+1 edges after the accepting edge.
- R5: Lanes that read the same word of a bank count as a single access, so they add no issue cycle beyond that word.
- R6: req_ready is high when idle. It is low from the accepting edge until the response, and it is high again during the rsp_valid cycle.
- R7: When several lanes of one group store to the same word, the highest-numbered of those lanes sets the stored value.
- R8: An inactive lane makes no bank access: its store data is not written. Its rsp_rdata slot is zero.
- R9: A store lane's rsp_rdata slot is zero. A lane that reads a word stored by another lane of the same group gets the value from before the group.
- R10: After reset, req_ready is 1, rsp_valid is 0 and rsp_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request group is presented |
| req_ready | output | 1 | Block is idle and takes the group on this edge |
| req_active | input | 16 | Per-lane active bit |
| req_store | input | 16 | Per-lane store (1) or read (0) |
| req_addr | input | 128 | Lane l word address in bits [8l+7:8l] |
| req_wdata | input | 512 | Lane l store data in bits [32l+31:32l] |
| rsp_valid | output | 1 | One-cycle pulse: group finished, rsp_rdata valid |
| rsp_rdata | output | 512 | Lane l read data in bits [32l+31:32l] |

## Verification
A wrong pending mask or a grant that skips a lane shows at the ports in one of two ways. rsp_valid may arrive at the wrong edge, or it may never arrive. A lane may also miss its read data or its store. The bench therefore times every response against the per-bank count of distinct words, and it compares every lane slot against a memory model. A lost store is caught at the next group that reads the word, usually a few dozen cycles later. A bad merge of same-word lanes shows up as an extra issue cycle in the same response.

// File: rtl/sp_pkg.sv
package sp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_FINISH
  } sp_state_e;

  // bank that owns a word address: consecutive words go to consecutive banks
  function automatic int unsigned bank_idx(input int unsigned word_addr,
                                           input int unsigned nbanks);
    return word_addr % nbanks;
  endfunction

  // row inside the owning bank
  function automatic int unsigned row_idx(input int unsigned word_addr,
                                          input int unsigned nbanks);
    return word_addr / nbanks;
  endfunction

endpackage

// File: rtl/sp_bank.sv
module sp_bank #(
  parameter int DW = 32,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd
);
  localparam int ROWS = 1 << RW;

  logic [DW-1:0] mem [ROWS];

  // read returns the old contents when a store hits the same row
  always_ff @(posedge clk) begin
    if (en) begin
      rd <= mem[row];
      if (we) mem[row] <= wd;
    end
  end

endmodule

// File: rtl/sp_bank_arb.sv
module sp_bank_arb
  import sp_pkg::*;
#(
  parameter int          LANES   = 16,
  parameter int          AW      = 8,
  parameter int          DW      = 32,
  parameter int unsigned BANKS   = 16,
  parameter int unsigned BANK_ID = 0,
  parameter int          RW      = 4
) (
  input  logic [LANES-1:0]    pend,
  input  logic [LANES*AW-1:0] addr,
  input  logic [LANES-1:0]    store,
  input  logic [LANES*DW-1:0] wdata,
  output logic [LANES-1:0]    grant,
  output logic                en,
  output logic                we,
  output logic [RW-1:0]       row,
  output logic [DW-1:0]       wd
);
  logic [LANES-1:0] hit;
  logic [AW-1:0]    lead;

  always_comb begin
    hit   = '0;
    grant = '0;
    en    = 1'b0;
    lead  = '0;
    we    = 1'b0;
    wd    = '0;
    for (int l = 0; l < LANES; l++)
      hit[l] = pend[l] && (bank_idx(32'(addr[l*AW +: AW]), BANKS) == BANK_ID);
    // lowest pending lane in this bank picks the word served this cycle
    for (int l = 0; l < LANES; l++)
      if (hit[l] && !en) begin
        en   = 1'b1;
        lead = addr[l*AW +: AW];
      end
    // every pending lane on that same word rides along (broadcast / merge)
    for (int l = 0; l < LANES; l++)
      grant[l] = hit[l] && (addr[l*AW +: AW] == lead);
    // ascending scan: the highest storing lane overwrites earlier ones
    for (int l = 0; l < LANES; l++)
      if (grant[l] && store[l]) begin
        we = 1'b1;
        wd = wdata[l*DW +: DW];
      end
  end

  assign row = RW'(row_idx(32'(lead), BANKS));

endmodule

// File: rtl/sp_conflict_serializer.sv
module sp_conflict_serializer
  import sp_pkg::*;
#(
  parameter int          LANES = 16,
  parameter int unsigned BANKS = 16,
  parameter int          AW    = 8,
  parameter int          DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LANES-1:0]    req_active,
  input  logic [LANES-1:0]    req_store,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES*DW-1:0] req_wdata,
  output logic                rsp_valid,
  output logic [LANES*DW-1:0] rsp_rdata
);
  localparam int BW = $clog2(BANKS);
  localparam int RW = AW - BW;
  localparam int CW = $clog2(LANES + 1);

  sp_state_e           state;
  logic [LANES-1:0]    pend_q;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES-1:0]    store_q;
  logic [LANES*DW-1:0] wdata_q;
  logic [LANES-1:0]    rd_srv_q;
  logic [DW-1:0]       lane_res [LANES];
  logic                rsp_v_q;
  logic [CW-1:0]       slot_cnt;

  // named internal events
  logic                issuing;
  logic                accept;
  logic [LANES-1:0]    grant_all;
  logic [LANES-1:0]    left_after;
  logic [BW-1:0]       lane_bank [LANES];

  logic [LANES-1:0]    bank_grant [BANKS];
  logic [BANKS-1:0]    bank_en;
  logic [BANKS-1:0]    bank_we;
  logic [RW-1:0]       bank_row [BANKS];
  logic [DW-1:0]       bank_wd  [BANKS];
  logic [DW-1:0]       bank_q   [BANKS];

  assign issuing    = (state == ST_ISSUE);
  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_ready && req_valid;
  assign left_after = pend_q & ~grant_all;
  assign rsp_valid  = rsp_v_q;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    sp_bank_arb #(
      .LANES(LANES), .AW(AW), .DW(DW), .BANKS(BANKS),
      .BANK_ID(b), .RW(RW)
    ) u_arb (
      .pend  (pend_q),
      .addr  (addr_q),
      .store (store_q),
      .wdata (wdata_q),
      .grant (bank_grant[b]),
      .en    (bank_en[b]),
      .we    (bank_we[b]),
      .row   (bank_row[b]),
      .wd    (bank_wd[b])
    );

    sp_bank #(.DW(DW), .RW(RW)) u_ram (
      .clk (clk),
      .en  (bank_en[b] && issuing),
      .we  (bank_we[b] && issuing),
      .row (bank_row[b]),
      .wd  (bank_wd[b]),
      .rd  (bank_q[b])
    );
  end

  always_comb begin
    grant_all = '0;
    for (int b = 0; b < BANKS; b++) grant_all = grant_all | bank_grant[b];
    for (int l = 0; l < LANES; l++)
      lane_bank[l] = BW'(bank_idx(32'(addr_q[l*AW +: AW]), BANKS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pend_q   <= '0;
      addr_q   <= '0;
      store_q  <= '0;
      wdata_q  <= '0;
      rd_srv_q <= '0;
      rsp_v_q  <= 1'b0;
      slot_cnt <= '0;
    end else begin
      rsp_v_q <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          pend_q   <= req_active;
          addr_q   <= req_addr;
          store_q  <= req_store;
          wdata_q  <= req_wdata;
          rd_srv_q <= '0;
          slot_cnt <= '0;
          state    <= ST_ISSUE;
        end
        ST_ISSUE: begin
          pend_q   <= left_after;
          rd_srv_q <= grant_all & ~store_q;
          slot_cnt <= slot_cnt + 1'b1;
          if (left_after == '0) state <= ST_FINISH;
        end
        ST_FINISH: begin
          rd_srv_q <= '0;
          rsp_v_q  <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // bank read data lands one cycle after its slot; steer it to served lanes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LANES; l++) lane_res[l] <= '0;
    end else if (accept) begin
      for (int l = 0; l < LANES; l++) lane_res[l] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++)
        if (rd_srv_q[l]) lane_res[l] <= bank_q[lane_bank[l]];
    end
  end

  always_comb
    for (int l = 0; l < LANES; l++) rsp_rdata[l*DW +: DW] = lane_res[l];

  AST_ISSUE_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    issuing && (pend_q != '0) |-> (grant_all != '0)); // R4
  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    issuing |-> ((grant_all & ~pend_q) == '0)); // R8
  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    issuing |-> (slot_cnt < CW'(LANES))); // R4
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_v_q |=> !rsp_v_q); // R4
  AST_RSP_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_v_q |-> req_ready); // R6
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready && !rsp_v_q); // R6

endmodule

// File: tb/sp_conflict_serializer_bench.sv
module sp_conflict_serializer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 16;
  localparam int BANKS = 16;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int WORDS = 1 << AW;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                req_valid = 1'b0;
  logic                req_ready;
  logic [LANES-1:0]    req_active = '0;
  logic [LANES-1:0]    req_store = '0;
  logic [LANES*AW-1:0] req_addr = '0;
  logic [LANES*DW-1:0] req_wdata = '0;
  logic                rsp_valid;
  logic [LANES*DW-1:0] rsp_rdata;

  sp_conflict_serializer u_sp_conflict_serializer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_active(req_active), .req_store(req_store), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [DW-1:0]       model [WORDS];
  logic [LANES*DW-1:0] exp_q [$];
  int                  lat_q [$];
  int                  acc_q [$];
  string               tag_q [$];

  task automatic check(input bit ok, input string req, input logic [LANES*DW-1:0] act,
                       input logic [LANES*DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: computes expected data and issue count, pushes them, drives the group
  task automatic run_group(input logic [LANES-1:0] act, input logic [LANES-1:0] st,
                           input logic [LANES*AW-1:0] ad, input logic [LANES*DW-1:0] wd,
                           input string tag);
    logic [LANES*DW-1:0] exp;
    int k;
    exp = '0;
    k = 1;
    for (int b = 0; b < BANKS; b++) begin
      int cnt;
      cnt = 0;
      for (int l = 0; l < LANES; l++) begin
        bit fresh;
        fresh = act[l] && (int'(ad[l*AW +: AW]) % BANKS == b);
        for (int m = 0; m < l; m++)
          if (act[m] && ad[m*AW +: AW] == ad[l*AW +: AW]) fresh = 0;
        if (fresh) cnt++;
      end
      if (cnt > k) k = cnt;
    end
    for (int l = 0; l < LANES; l++)
      if (act[l] && !st[l]) exp[l*DW +: DW] = model[ad[l*AW +: AW]];
    for (int l = 0; l < LANES; l++)
      if (act[l] && st[l]) model[ad[l*AW +: AW]] = wd[l*DW +: DW];
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_active = act; req_store = st; req_addr = ad; req_wdata = wd;
    exp_q.push_back(exp); lat_q.push_back(k + 1); acc_q.push_back(cyc + 1);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R6 busy after accept", {511'd0, req_ready}, '0);
  endtask

  // monitor: pops and compares at each response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R4 unexpected response", rsp_rdata, '0);
      end else begin
        logic [LANES*DW-1:0] e;
        int lat, acc;
        string t;
        e = exp_q.pop_front(); lat = lat_q.pop_front(); acc = acc_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_rdata == e, {t, " data"}, rsp_rdata, e);
        check(cyc - acc == lat, {t, " R4 latency"}, (cyc - acc), lat);
        check(req_ready, "R6 ready with response", {511'd0, req_ready}, 1);
      end
    end
  end

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return 32'h5A00_0000 ^ (a * 32'h0001_0203) ^ (salt << 20);
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [LANES*AW-1:0] ad;
    logic [LANES*DW-1:0] wd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(req_ready == 1'b1, "R10 ready", {511'd0, req_ready}, 1);
    check(rsp_valid == 1'b0, "R10 valid", {511'd0, rsp_valid}, 0);
    check(rsp_rdata == '0, "R10 rdata", rsp_rdata, '0);

    // fill memory: stride-1 stores, one bank per lane (R1, R2)
    for (int g = 0; g < WORDS / LANES; g++) begin
      for (int l = 0; l < LANES; l++) begin
        ad[l*AW +: AW] = AW'(g * LANES + l);
        wd[l*DW +: DW] = pat(g * LANES + l, 0);
      end
      run_group('1, '1, ad, wd, "R2 fill");
    end
    // R1 R2 stride-1 read back
    for (int l = 0; l < LANES; l++) ad[l*AW +: AW] = AW'(32 + l);
    run_group('1, '0, ad, '0, "R1 R2 stride1");
    // R1 scrambled permutation over banks, still one cycle
    for (int l = 0; l < LANES; l++) ad[l*AW +: AW] = AW'(((l * 7) % 16) + 16 * (l % 5));
    run_group('1, '0, ad, '0, "R1 R2 permutation");
    // R3 broadcast
    for (int l = 0; l < LANES; l++) ad[l*AW +: AW] = 8'd5;
    run_group('1, '0, ad, '0, "R3 broadcast");
    // R4 stride 2 -> 2 cycles, stride 8 -> 8, stride 16 -> 16
    for (int l = 0; l < LANES; l++) ad[l*AW +: AW] = AW'(2 * l);
    run_group('1, '0, ad, '0, "R4 stride2");
    for (int l = 0; l < LANES; l++) ad[l*AW +: AW] = AW'(8 * l);
    run_group('1, '0, ad, '0, "R4 stride8");
    for (int l = 0; l < LANES; l++) ad[l*AW +: AW] = AW'(16 * l);
    run_group('1, '0, ad, '0, "R4 stride16");
    // R5 two words in bank 3, each read by eight lanes -> 2 cycles
    for (int l = 0; l < LANES; l++) ad[l*AW +: AW] = (l < 8) ? 8'd3 : 8'd19;
    run_group('1, '0, ad, '0, "R5 merge");
    // R7 all lanes store word 40, then read it
    for (int l = 0; l < LANES; l++) begin
      ad[l*AW +: AW] = 8'd40;
      wd[l*DW +: DW] = pat(40, l + 1);
    end
    run_group('1, '1, ad, wd, "R7 collide store");
    run_group('1, '0, ad, '0, "R7 readback");
    // R8 inactive lanes store nothing and read zero
    for (int l = 0; l < LANES; l++) begin
      ad[l*AW +: AW] = AW'(100 + l);
      wd[l*DW +: DW] = pat(100 + l, 9);
    end
    run_group(16'h00FF, '1, ad, wd, "R8 partial store");
    run_group('1, '0, ad, '0, "R8 readback");
    run_group(16'hA5A5, '0, ad, '0, "R8 zero inactive");
    run_group('0, '0, ad, '0, "R8 empty group");
    // R9 read and store of one word in the same group
    ad = '0; wd = '0;
    ad[0 +: AW] = 8'd50; ad[AW +: AW] = 8'd50; wd[DW +: DW] = 32'hCAFE_0050;
    run_group(16'h0003, 16'h0002, ad, wd, "R9 read before store");
    run_group(16'h0001, 16'h0000, ad, '0, "R9 new value");
    // mixed random groups with a narrow address range for conflicts
    for (int g = 0; g < 40; g++) begin
      logic [LANES-1:0] act, st;
      act = LANES'($urandom);
      st = '0;
      for (int l = 0; l < LANES; l++) begin
        ad[l*AW +: AW] = AW'($urandom_range(0, 63));
        wd[l*DW +: DW] = $urandom;
        st[l] = ($urandom_range(0, 3) == 0);
      end
      run_group(act, st, ad, wd, "R4 R7 R9 mixed");
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule